// File: doc/BRIEF.md
# External Bus Write Cycle Controller

This block is a bus master that runs one write transfer at a time on an external 32-bit memory bus with asynchronous-style timing. An internal requester presents an address, write data, a size code, an access-type code and a chip-select enable. The controller then drives the external address, size and type codes, chip select, output enable, read/write strobe, the active-low per-byte enables and the byte lanes of the data bus. When the transfer is finished it gives a one-cycle completion pulse back to the requester.

A transfer has three parts. An address phase always lasts one clock. It is followed by zero or more wait states, each one clock long. The transfer closes with a final data phase of one clock. Two sources can acknowledge a transfer, and the controller treats them the same way: an active-low input from the external slave and an active-high input from internal chip-select logic. An acknowledge seen in the address phase skips the wait states. If no acknowledge arrives within `MAX_WAIT` wait states, the controller forces a completion that is flagged as a bus error.

The write data must arrive already placed on its byte lanes. The controller passes each byte lane through or blanks it according to the byte enables. The output-enable pin is kept negated on every cycle, because the controller only writes.

Top module: `xbus_write_master`

## Requirements
- R1: While reset is applied and afterwards with no request, the block shows reqReady=1, reqDone=0, reqErr=0, busCsN=1, busRwN=1, busOeN=1, busBeN=4'hF, busDataOe=0, busDataOut=0, and busAddr, busSize and busType all zero.
- R2: A request is taken on a clock edge where reqReady and reqValid are both high. In the next cycle (the address phase) the block drives busAddr, busSize and busType with the captured values, busCsN = !reqCsEn, busRwN=0 and busOeN=1.
- R3: busBeN is active low. Bit 3 gates D[31:24], bit 2 gates D[23:16], bit 1 gates D[15:8] and bit 0 gates D[7:0], so address byte offset 0 maps to D[31:24]. Size 01 is a byte at offset addr[1:0]. Size 10 is a halfword at offset addr[1:0] with addr[0] ignored. Size 00 or 11 is a word on all four lanes.
- R4: An acknowledge present during the address phase moves the block straight to the final phase in the next cycle, with no wait state. An acknowledge is busAckN=0 or csAck=1.
- R5: With no acknowledge in the address phase, the block inserts wait states of one clock each. The final phase follows the first wait state in which an acknowledge is present.
- R6: Write data and busDataOe are driven from the first wait state onward. They are never driven in the address phase.
- R7: In a transfer without wait states, write data first appears in the final phase.
- R8: Address, size, type, chip select, read/write and write data stay unchanged from their first driven cycle through the final phase. The byte enables stay asserted through the final phase and are all negated in the cycle after it.
- R9: reqDone is high for exactly one cycle, during the final phase. reqReady is high again in the following cycle.
- R10: If MAX_WAIT wait states pass with no acknowledge, the final phase follows and reqErr is high together with reqDone. An acknowledge in the last allowed wait state completes the transfer without an error.
- R11: reqValid and acknowledges are ignored outside idle and idle respectively: a request presented while a transfer runs does not alter it, and an acknowledge in idle starts nothing.
- R12: Only lanes whose byte enable is active are driven. Every other lane has its busDataOe bit low and its busDataOut byte zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Write request present |
| reqAddr | input | ADDR_W | Byte address of the write |
| reqData | input | DATA_W | Write data, already placed on its lanes |
| reqSize | input | 2 | Size code: 01 byte, 10 halfword, 00/11 word |
| reqType | input | 3 | Access-type code, passed to the bus |
| reqCsEn | input | 1 | Assert chip select for this transfer |
| reqReady | output | 1 | Controller idle, can take a request |
| reqDone | output | 1 | One-cycle completion pulse |
| reqErr | output | 1 | Completion was forced by timeout |
| busAckN | input | 1 | External acknowledge, active low |
| csAck | input | 1 | Internal chip-select acknowledge, active high |
| busAddr | output | ADDR_W | External address |
| busSize | output | 2 | External size code |
| busType | output | 3 | External access-type code |
| busCsN | output | 1 | Chip select, active low |
| busOeN | output | 1 | Output enable, active low, held negated |
| busRwN | output | 1 | Read/write: low marks a write |
| busBeN | output | DATA_W/8 | Byte enables, active low |
| busDataOut | output | DATA_W | Write data toward the data pads |
| busDataOe | output | DATA_W/8 | Per-lane pad drive enable |

## Verification
A phase register that holds a wrong value shows up at the pins in the same cycle, because every bus output is decoded from the phase and the captured request. A stuck or skipped wait state makes busDataOe or reqDone disagree with the reference model in the first cycle where the acknowledge should have taken effect. A corrupt wait counter first appears at the timeout boundary, as a reqErr that is too early, too late or missing. A wrong byte-enable decode appears in the address phase on busBeN, and one cycle later on busDataOe.

// File: rtl/ewc_pkg.sv
package ewc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_WAIT = 2'd2,
    PH_DATA = 2'd3
  } ewcPhase_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;
    logic addrPhase;
    logic waitPhase;
    logic dataPhase;
  } ewcStrobe_t;

  localparam logic [1:0] SZ_WORD = 2'b00;
  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_HALF = 2'b10;

endpackage

// File: rtl/ewc_control.sv
module ewc_control
  import ewc_pkg::*;
#(
  parameter int MAX_WAIT = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       anyAck,
  output ewcStrobe_t stb,
  output logic       reqReady,
  output logic       reqDone,
  output logic       reqErr
);

  localparam int CNT_W = $clog2(MAX_WAIT + 1);
  localparam logic [CNT_W-1:0] LAST_WAIT = CNT_W'(MAX_WAIT - 1);

  ewcPhase_e        state, stateNxt;
  logic [CNT_W-1:0] waitCnt, waitNxt;
  logic             errFlag, errNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= PH_IDLE;
      waitCnt <= '0;
      errFlag <= 1'b0;
    end else begin
      state   <= stateNxt;
      waitCnt <= waitNxt;
      errFlag <= errNxt;
    end
  end

  always_comb begin
    stateNxt = state;
    waitNxt  = waitCnt;
    errNxt   = errFlag;
    case (state)
      PH_IDLE: if (reqValid) stateNxt = PH_ADDR;
      PH_ADDR: begin
        waitNxt  = '0;
        errNxt   = 1'b0;
        stateNxt = anyAck ? PH_DATA : PH_WAIT;
      end
      PH_WAIT: begin
        if (anyAck) begin
          stateNxt = PH_DATA;
        end else if (waitCnt == LAST_WAIT) begin
          stateNxt = PH_DATA;
          errNxt   = 1'b1;
        end else begin
          waitNxt = waitCnt + 1'b1;
        end
      end
      PH_DATA: stateNxt = PH_IDLE;
      default: stateNxt = PH_IDLE;
    endcase
  end

  assign stb.capture   = (state == PH_IDLE) && reqValid;
  assign stb.addrPhase = (state == PH_ADDR);
  assign stb.waitPhase = (state == PH_WAIT);
  assign stb.dataPhase = (state == PH_DATA);

  assign reqReady = (state == PH_IDLE);
  assign reqDone  = (state == PH_DATA);
  assign reqErr   = (state == PH_DATA) && errFlag;

  assert_ack_skips_wait_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_ADDR && anyAck) |=> (state == PH_DATA));

  assert_wait_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_WAIT) |-> (waitCnt <= LAST_WAIT));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |=> (!reqDone && reqReady));

  assert_wait_ack_ends_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_WAIT && anyAck) |=> (reqDone && !reqErr));

endmodule

// File: rtl/ewc_datapath.sv
module ewc_datapath
  import ewc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ewcStrobe_t        stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [1:0]        reqSize,
  input  logic [2:0]        reqType,
  input  logic              reqCsEn,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  output logic [2:0]        busType,
  output logic              busCsN,
  output logic              busOeN,
  output logic              busRwN,
  output logic [DATA_W/8-1:0] busBeN,
  output logic [DATA_W-1:0] busDataOut,
  output logic [DATA_W/8-1:0] busDataOe
);

  localparam int LANES = DATA_W / 8;
  localparam int IDX_W = $clog2(LANES);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [1:0]        sizeQ;
  logic [2:0]        typeQ;
  logic              csQ;
  logic [LANES-1:0]  beQ;

  logic [IDX_W:0]    nBytes;
  logic [IDX_W-1:0]  offset;
  logic [LANES-1:0]  beNew;
  logic              active;
  logic              driveData;

  // byte count and aligned lane offset of the new request
  always_comb begin
    case (reqSize)
      SZ_BYTE: nBytes = (IDX_W + 1)'(1);
      SZ_HALF: nBytes = (IDX_W + 1)'(2);
      default: nBytes = (IDX_W + 1)'(LANES);
    endcase
    offset = reqAddr[IDX_W-1:0] & ~(nBytes[IDX_W-1:0] - 1'b1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      sizeQ <= '0;
      typeQ <= '0;
      csQ   <= 1'b0;
      beQ   <= '0;
    end else if (stb.capture) begin
      addrQ <= reqAddr;
      dataQ <= reqData;
      sizeQ <= reqSize;
      typeQ <= reqType;
      csQ   <= reqCsEn;
      beQ   <= beNew;
    end
  end

  assign active    = stb.addrPhase | stb.waitPhase | stb.dataPhase;
  assign driveData = stb.waitPhase | stb.dataPhase;

  assign busAddr = active ? addrQ : '0;
  assign busSize = active ? sizeQ : 2'b00;
  assign busType = active ? typeQ : 3'b000;
  assign busCsN  = !(active && csQ);
  assign busRwN  = !active;
  assign busOeN  = 1'b1;
  assign busBeN  = active ? ~beQ : '1;

  // lane k counts from the most significant byte (big-endian)
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [IDX_W:0] LANE_K = (IDX_W + 1)'(k);
    localparam int BIT = LANES - 1 - k;
    assign beNew[BIT] = (LANE_K >= {1'b0, offset}) &&
                        (LANE_K < ({1'b0, offset} + nBytes));
    assign busDataOe[BIT] = driveData & beQ[BIT];
    assign busDataOut[BIT*8 +: 8] = busDataOe[BIT] ? dataQ[BIT*8 +: 8] : 8'h00;
  end

  assert_ctrl_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.waitPhase || stb.dataPhase) |->
      ($stable(busAddr) && $stable(busSize) && $stable(busType) &&
       $stable(busCsN) && $stable(busRwN) && $stable(busBeN)));

  assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.dataPhase && $past(stb.waitPhase)) |-> $stable(busDataOut));

  assert_be_count_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.addrPhase |-> ($countones(~busBeN) == 1 || $countones(~busBeN) == 2 ||
                       $countones(~busBeN) == LANES));

endmodule

// File: rtl/xbus_write_master.sv
module xbus_write_master
  import ewc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int MAX_WAIT = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqData,
  input  logic [1:0]          reqSize,
  input  logic [2:0]          reqType,
  input  logic                reqCsEn,
  output logic                reqReady,
  output logic                reqDone,
  output logic                reqErr,
  input  logic                busAckN,
  input  logic                csAck,
  output logic [ADDR_W-1:0]   busAddr,
  output logic [1:0]          busSize,
  output logic [2:0]          busType,
  output logic                busCsN,
  output logic                busOeN,
  output logic                busRwN,
  output logic [DATA_W/8-1:0] busBeN,
  output logic [DATA_W-1:0]   busDataOut,
  output logic [DATA_W/8-1:0] busDataOe
);

  ewcStrobe_t stb;
  logic       anyAck;

  assign anyAck = !busAckN || csAck;

  ewc_control #(.MAX_WAIT(MAX_WAIT)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .anyAck   (anyAck),
    .stb      (stb),
    .reqReady (reqReady),
    .reqDone  (reqDone),
    .reqErr   (reqErr)
  );

  ewc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .reqAddr    (reqAddr),
    .reqData    (reqData),
    .reqSize    (reqSize),
    .reqType    (reqType),
    .reqCsEn    (reqCsEn),
    .busAddr    (busAddr),
    .busSize    (busSize),
    .busType    (busType),
    .busCsN     (busCsN),
    .busOeN     (busOeN),
    .busRwN     (busRwN),
    .busBeN     (busBeN),
    .busDataOut (busDataOut),
    .busDataOe  (busDataOe)
  );

  assert_be_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |=> (busBeN == '1 && busDataOe == '0));

  assert_addr_phase_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid) |=> (!busRwN && busDataOe == '0 && !reqDone));

endmodule

// File: tb/xbus_write_master_test.sv
module xbus_write_master_test;

  localparam int MAX_WAIT = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b1;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqData = '0;
  logic [1:0]  reqSize = '0;
  logic [2:0]  reqType = '0;
  logic        reqCsEn = 1'b0;
  logic        reqReady, reqDone, reqErr;
  logic        busAckN = 1'b1;
  logic        csAck = 1'b0;
  logic [31:0] busAddr;
  logic [1:0]  busSize;
  logic [2:0]  busType;
  logic        busCsN, busOeN, busRwN;
  logic [3:0]  busBeN;
  logic [31:0] busDataOut;
  logic [3:0]  busDataOe;

  always #5 clk = ~clk;

  xbus_write_master #(.ADDR_W(32), .DATA_W(32), .MAX_WAIT(MAX_WAIT)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqData(reqData), .reqSize(reqSize), .reqType(reqType), .reqCsEn(reqCsEn),
    .reqReady(reqReady), .reqDone(reqDone), .reqErr(reqErr),
    .busAckN(busAckN), .csAck(csAck), .busAddr(busAddr), .busSize(busSize),
    .busType(busType), .busCsN(busCsN), .busOeN(busOeN), .busRwN(busRwN),
    .busBeN(busBeN), .busDataOut(busDataOut), .busDataOe(busDataOe)
  );

  int nTests = 0;
  int nFail = 0;
  bit finished = 1'b0;

  // reference model state: 0 idle, 1 address, 2 wait, 3 final
  int          mPhase = 0;
  int          mWaits = 0;
  bit          mErr = 1'b0;
  logic [31:0] mAddr = '0, mData = '0;
  logic [1:0]  mSize = '0;
  logic [2:0]  mType = '0;
  bit          mCs = 1'b0;

  int ackAfter = 0;   // wait states before ack, -1 never
  bit ackExt = 1'b1;
  bit idleNoise = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] beRef(input logic [31:0] a, input logic [1:0] s);
    int n;
    int off;
    logic [3:0] r;
    n = (s == 2'b01) ? 1 : (s == 2'b10) ? 2 : 4;
    off = int'(a[1:0]) - (int'(a[1:0]) % n);
    r = '0;
    for (int k = 0; k < 4; k++)
      if (k >= off && k < off + n) r[3-k] = 1'b1;
    return r;
  endfunction

  // model advances on the edge with the inputs the design also sees
  always @(posedge clk) begin
    bit ack;
    ack = !busAckN || csAck;
    if (!rstN) begin
      mPhase = 0; mWaits = 0; mErr = 1'b0;
    end else begin
      case (mPhase)
        0: if (reqValid) begin
             mAddr = reqAddr; mData = reqData; mSize = reqSize;
             mType = reqType; mCs = reqCsEn; mPhase = 1;
           end
        1: begin
             mErr = 1'b0; mWaits = 0;
             mPhase = ack ? 3 : 2;
           end
        2: begin
             if (ack) mPhase = 3;
             else if (mWaits + 1 == MAX_WAIT) begin mPhase = 3; mErr = 1'b1; end
             else mWaits++;
           end
        default: mPhase = 0;
      endcase
    end
  end

  // acknowledge generator driven from the model's view of the transfer
  always @(negedge clk) begin
    bit now;
    now = (mPhase == 1 && ackAfter == 0) ||
          (mPhase == 2 && mWaits == ackAfter - 1) ||
          (mPhase == 0 && idleNoise);
    busAckN = !(now && ackExt);
    csAck   = now && !ackExt;
  end

  // compare every output on every cycle
  always @(negedge clk) begin
    bit act, drv;
    logic [3:0] be, expOe;
    logic [31:0] expData;
    if (!finished) begin
      act = (mPhase != 0);
      drv = (mPhase == 2 || mPhase == 3);
      be = act ? beRef(mAddr, mSize) : 4'h0;
      expOe = drv ? be : 4'h0;
      expData = '0;
      for (int b = 0; b < 4; b++)
        if (expOe[b]) expData[b*8 +: 8] = mData[b*8 +: 8];
      check(busAddr == (act ? mAddr : 32'h0), "R2", "busAddr", busAddr, act ? mAddr : 32'h0);
      check(busSize == (act ? mSize : 2'b0), "R2", "busSize", 32'(busSize), act ? 32'(mSize) : 32'h0);
      check(busType == (act ? mType : 3'b0), "R2", "busType", 32'(busType), act ? 32'(mType) : 32'h0);
      check(busCsN == !(act && mCs), "R2", "busCsN", 32'(busCsN), 32'(!(act && mCs)));
      check(busRwN == !act, "R2", "busRwN", 32'(busRwN), 32'(!act));
      check(busOeN == 1'b1, "R1", "busOeN", 32'(busOeN), 32'h1);
      check(busBeN == ~be, "R3", "busBeN", 32'(busBeN), 32'(~be));
      check(busDataOe == expOe, "R6", "busDataOe", 32'(busDataOe), 32'(expOe));
      check(busDataOut == expData, "R12", "busDataOut", busDataOut, expData);
      check(reqDone == (mPhase == 3), "R9", "reqDone", 32'(reqDone), 32'(mPhase == 3));
      check(reqErr == (mPhase == 3 && mErr), "R10", "reqErr", 32'(reqErr), 32'(mPhase == 3 && mErr));
      check(reqReady == (mPhase == 0), "R11", "reqReady", 32'(reqReady), 32'(mPhase == 0));
    end
  end

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  task automatic doWrite(input logic [31:0] a, input logic [31:0] d, input logic [1:0] s,
                         input logic [2:0] t, input bit cs, input int ackIn, input bit ext,
                         input int expWaits, input bit expErr, input string tag);
    int cycles;
    @(negedge clk);
    ackAfter = ackIn; ackExt = ext;
    reqAddr = a; reqData = d; reqSize = s; reqType = t; reqCsEn = cs; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    // scramble the request inputs: the bus must hold captured values (R8)
    reqAddr = ~a; reqData = ~d; reqSize = ~s; reqType = ~t; reqCsEn = !cs;
    cycles = 1;
    if (expWaits == 0) begin
      // R7: address phase carries no data
      check(busDataOe == 4'h0, "R7", "no data in address phase", 32'(busDataOe), 32'h0);
    end
    while (!reqDone && cycles < 100) begin
      @(negedge clk);
      cycles++;
    end
    check(cycles == 2 + expWaits, tag, "transfer length", 32'(cycles), 32'(2 + expWaits));
    check(reqErr == expErr, "R10", "completion error flag", 32'(reqErr), 32'(expErr));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL R9 watchdog: actual=hang expected=done");
      report();
    end
  end

  initial begin
    #1 rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R1: idle values under reset
    check(reqReady && !reqDone && busBeN == 4'hF && busCsN && busRwN && busDataOe == 0,
          "R1", "reset state", {busBeN, busDataOe, 20'h0, reqReady, reqDone, busCsN, busRwN},
          {4'hF, 4'h0, 20'h0, 4'b1011});
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(reqReady == 1'b1, "R1", "idle after reset", 32'(reqReady), 32'h1);

    // R4 R7: byte, external ack in address phase
    doWrite(32'h0000_1001, 32'h11AA_2233, 2'b01, 3'd5, 1'b1, 0, 1'b1, 0, 1'b0, "R4");
    // R5 R6: halfword, internal ack after two wait states
    doWrite(32'h0000_2002, 32'hCAFE_BEEF, 2'b10, 3'd1, 1'b1, 2, 1'b0, 2, 1'b0, "R5");
    // R4: word, internal ack immediately
    doWrite(32'h0000_3000, 32'h0102_0304, 2'b00, 3'd7, 1'b1, 0, 1'b0, 0, 1'b0, "R4");
    // R3: byte at offset 3, one wait state
    doWrite(32'h0000_4003, 32'h5566_7788, 2'b01, 3'd2, 1'b1, 1, 1'b1, 1, 1'b0, "R5");
    // R3: odd halfword address aligns to lanes 0-1
    doWrite(32'h0000_5001, 32'h9ABC_DEF0, 2'b10, 3'd3, 1'b1, 3, 1'b1, 3, 1'b0, "R5");
    // R3: reserved size 11 acts as word, chip select disabled
    doWrite(32'h0000_6002, 32'hFFEE_DDCC, 2'b11, 3'd4, 1'b0, 0, 1'b1, 0, 1'b0, "R4");
    // R10: no acknowledge at all
    doWrite(32'h0000_7000, 32'h1234_5678, 2'b00, 3'd6, 1'b1, -1, 1'b1, MAX_WAIT, 1'b1, "R10");
    // R10: acknowledge in the last allowed wait state
    doWrite(32'h0000_8001, 32'h8765_4321, 2'b01, 3'd0, 1'b1, MAX_WAIT, 1'b0, MAX_WAIT, 1'b0, "R10");

    // R11: acknowledges while idle start nothing
    @(negedge clk);
    idleNoise = 1'b1;
    repeat (4) @(negedge clk);
    check(reqReady == 1'b1 && busRwN == 1'b1, "R11", "ack in idle ignored",
          {30'h0, reqReady, busRwN}, 32'h3);
    idleNoise = 1'b0;

    // R11: request held during a transfer is taken only after it ends
    @(negedge clk);
    ackAfter = 2; ackExt = 1'b1;
    reqAddr = 32'h0000_A000; reqData = 32'hA5A5_A5A5; reqSize = 2'b00; reqType = 3'd1;
    reqCsEn = 1'b1; reqValid = 1'b1;
    @(negedge clk);
    reqAddr = 32'h0000_B002; reqData = 32'h5A5A_5A5A; reqSize = 2'b10; reqType = 3'd2;
    check(busAddr == 32'h0000_A000, "R11", "first request on bus", busAddr, 32'h0000_A000);
    while (!reqDone) @(negedge clk);
    @(negedge clk);
    check(reqReady == 1'b1, "R9", "ready after done", 32'(reqReady), 32'h1);
    @(negedge clk);
    reqValid = 1'b0;
    check(busAddr == 32'h0000_B002, "R11", "held request taken after idle", busAddr, 32'h0000_B002);
    while (!reqDone) @(negedge clk);
    repeat (3) @(negedge clk);
    report();
  end

endmodule